// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Polarity Swap

This block decides, on every comparison, whether a charge pump has to push the loop filter voltage up or pull it down. Two pulse trains come in: one from the divided reference and one from the divided VCO. Both are sampled in a fast system-clock domain. Only their rising edges count, and each rising edge sets one of two request flip-flops. Once both flip-flops are set, a short joint interval of a fixed number of clock cycles runs, and then both are cleared together. The detector therefore responds to frequency error as well as phase error. Because every comparison produces a pulse of non-zero width on both lines, very small phase errors still make the pump act.

A polarity input exchanges the two request lines, so the same detector can serve an inverting or a non-inverting loop filter. A drive-enable output tells the pump driver when to leave its high-impedance state, which is whenever either request is active. A current-select output carries the full/half current choice to the analog side.

Top module: `phase_freq_detector`

## Requirements
- R1: While the synchronous active-low reset is applied, and in the first cycle after it, `pump_up_o`, `pump_dn_o` and `pump_en_o` are all 0.
- R2: With `cfg_invert_i` = 0, a rising edge on `ref_in` raises `pump_up_o`. If the first rising clock edge that samples `ref_in` high is edge n, the output is high after edge n+2.
- R3: With `cfg_invert_i` = 0, a rising edge on `vco_in` raises `pump_dn_o`, with the same latency as R2.
- R4: Once both requests are high, both stay high for exactly OVERLAP_CYC clock cycles (default 2) and then fall in the same cycle.
- R5: Rising edges on both inputs in the same cycle raise both outputs in the same cycle, and both stay high for exactly OVERLAP_CYC cycles. A zero phase error therefore still gives a pulse on each line.
- R6: While `ref_in` keeps producing rising edges and `vco_in` produces none, `pump_up_o` stays high in every cycle without a break.
- R7: With `cfg_invert_i` = 1, the reference edge drives `pump_dn_o` and the VCO edge drives `pump_up_o`. Latency and overlap are unchanged.
- R8: `pump_en_o` is 1 exactly when `pump_up_o` or `pump_dn_o` is 1. When it is 0, the pump output is meant to float.
- R9: `pump_full_o` equals `cfg_full_i` in the same cycle. 1 selects full current and 0 selects half current.
- R10: Falling edges on either input do not set or clear any request.
- R11: A rising edge that takes effect in the same cycle as the joint clear wins for its own flip-flop. That request stays high and the other one falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Divided reference pulse train |
| vco_in | input | 1 | Divided VCO pulse train |
| cfg_invert_i | input | 1 | 1 swaps the two request outputs |
| cfg_full_i | input | 1 | Current choice: 1 full, 0 half |
| pump_up_o | output | 1 | Source-current request |
| pump_dn_o | output | 1 | Sink-current request |
| pump_en_o | output | 1 | Pump driver enable; 0 means high impedance |
| pump_full_o | output | 1 | Current-select line to the pump |

## Verification
Two functions can land in the same clock edge: the joint clear that ends the overlap interval, and the setting of a request by a fresh input edge. The bench provokes this by letting both flip-flops fire together and then re-raising the reference input so that its next edge arrives in exactly the clear cycle. It then expects the up request to survive while the down request falls. The reverse case, where both inputs rise together, is judged by requiring both lines to rise and fall together after the overlap interval.

// File: rtl/pfd_pkg.sv
// pfd_pkg
// Types shared by the phase-frequency detector modules.
// Assumes: bit 0 of every request vector belongs to the reference input and
// bit 1 to the VCO input.
package pfd_pkg;

    localparam int unsigned PFD_NUM_IN = 2;
    localparam int unsigned PFD_REF    = 0;
    localparam int unsigned PFD_VCO    = 1;

    // Request pair in detector terms, before any polarity swap.
    typedef struct packed {
        logic vco_req;
        logic ref_req;
    } pfd_req_t;

    // Pack a two-bit request vector into the struct.
    function automatic pfd_req_t pfd_pack(input logic [PFD_NUM_IN-1:0] v);
        pfd_req_t r;
        r.ref_req = v[PFD_REF];
        r.vco_req = v[PFD_VCO];
        return r;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
// pfd_edge_sync
// Brings one asynchronous pulse train into the clock domain through a chain
// of STAGES flip-flops. It then emits a one-cycle pulse for each rising edge
// it sees.
// Assumes: STAGES >= 2, and the input stays high or low for at least two
// clock cycles per phase, so no edge is lost in the chain.
module pfd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          hist_q;

    // First sampling stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= sig_i;
    end

    // Further metastability stages, one per generate index.
    for (genvar s = 1; s <= LAST; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    // Hold the previous settled level for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[LAST];
    end

    // Rising edge: settled high now, low one cycle ago.
    always_comb begin
        rise_o = chain_q[LAST] & ~hist_q;
    end

    // R10: an edge pulse never lasts two cycles, so a held level cannot re-set a flop.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_flop_pair.sv
// pfd_flop_pair
// The two edge-set request flip-flops with a shared clear. When both are
// set, a counter measures OVERLAP_CYC cycles and then clears both in the
// same edge. A new edge in that clear cycle takes priority for its own flop.
// Assumes: OVERLAP_CYC >= 1, and edge inputs are single-cycle pulses.
module pfd_flop_pair
    import pfd_pkg::*;
#(
    parameter int unsigned OVERLAP_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PFD_NUM_IN-1:0] edge_i,
    output pfd_req_t              req_o
);

    localparam int unsigned CNT_W    = $clog2(OVERLAP_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERLAP_CYC - 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(OVERLAP_CYC);

    logic [PFD_NUM_IN-1:0] req_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  both;
    logic                  clr;

    // Joint state and end of the overlap window.
    always_comb begin
        both = &req_q;
        clr  = both && (cnt_q == LAST_CNT);
    end

    // Overlap counter: runs only while both requests are held.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (both && !clr) cnt_q <= cnt_q + 1'b1;
        else                  cnt_q <= '0;
    end

    // One request flop per input; a set beats the joint clear.
    for (genvar i = 0; i < PFD_NUM_IN; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (!rst_n) req_q[i] <= 1'b0;
            else        req_q[i] <= (req_q[i] & ~clr) | edge_i[i];
        end
    end

    // Present the flop states as the shared request struct.
    always_comb begin
        req_o = pfd_pack(req_q);
    end

    // R2: a reference edge always leaves the reference request set.
    a_r2_ref_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i[PFD_REF] |=> req_q[PFD_REF]);

    // R3: a VCO edge always leaves the VCO request set.
    a_r3_vco_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i[PFD_VCO] |=> req_q[PFD_VCO]);

    // R4: the overlap counter never passes the window length.
    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        both |-> (cnt_q < LIMIT));

    // R4: at the window end, with no fresh edge, both requests fall.
    a_r4_joint_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (both && cnt_q == LAST_CNT && edge_i == '0) |=> (req_q == '0));

    // R11: a fresh reference edge in the clear cycle keeps its request.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && edge_i[PFD_REF] && !edge_i[PFD_VCO]) |=> (req_q[PFD_REF] && !req_q[PFD_VCO]));

    // R10: no request rises without an edge in the cycle before.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q[PFD_REF]) |-> $past(edge_i[PFD_REF]));

endmodule

// File: rtl/pfd_out_map.sv
// pfd_out_map
// Maps the detector requests onto the pump lines. It applies the polarity
// swap and derives the driver enable.
// Assumes: cfg_invert_i is quasi-static; a change takes effect at once.
module pfd_out_map
    import pfd_pkg::*;
(
    input  pfd_req_t req_i,
    input  logic     cfg_invert_i,
    output logic     up_o,
    output logic     dn_o,
    output logic     en_o
);

    // Route the requests to the up/down lines according to polarity.
    always_comb begin
        if (cfg_invert_i) begin
            up_o = req_i.vco_req;
            dn_o = req_i.ref_req;
        end else begin
            up_o = req_i.ref_req;
            dn_o = req_i.vco_req;
        end
    end

    // Driver leaves high impedance only while some request is active.
    always_comb begin
        en_o = req_i.ref_req | req_i.vco_req;
    end

endmodule

// File: rtl/phase_freq_detector.sv
// phase_freq_detector
// Top of the digital phase-frequency detector. It synchronises both pulse
// trains, sets a request flop per rising edge, clears both after a joint
// overlap window and maps the result onto swappable pump lines.
// Assumes: inputs are asynchronous to clk and much slower than it.
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OVERLAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic vco_in,
    input  logic cfg_invert_i,
    input  logic cfg_full_i,
    output logic pump_up_o,
    output logic pump_dn_o,
    output logic pump_en_o,
    output logic pump_full_o
);

    logic [PFD_NUM_IN-1:0] raw_in;
    logic [PFD_NUM_IN-1:0] edge_pulse;
    pfd_req_t              req;

    // Gather both inputs into the indexed vector.
    always_comb begin
        raw_in[PFD_REF] = ref_in;
        raw_in[PFD_VCO] = vco_in;
    end

    // One synchroniser and edge finder per input.
    for (genvar i = 0; i < PFD_NUM_IN; i++) begin : g_in
        pfd_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (raw_in[i]),
            .rise_o (edge_pulse[i])
        );
    end

    pfd_flop_pair #(
        .OVERLAP_CYC (OVERLAP_CYC)
    ) u_pair (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_pulse),
        .req_o  (req)
    );

    pfd_out_map u_map (
        .req_i        (req),
        .cfg_invert_i (cfg_invert_i),
        .up_o         (pump_up_o),
        .dn_o         (pump_dn_o),
        .en_o         (pump_en_o)
    );

    // Pass the current choice to the pump.
    always_comb begin
        pump_full_o = cfg_full_i;
    end

    // R5: coincident edges raise both pump lines together.
    a_r5_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse == '1) |=> (pump_up_o && pump_dn_o));

    // R7: with the swap active, the up line carries the VCO-side request.
    a_r7_swap: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invert_i |-> (pump_up_o == req.vco_req && pump_dn_o == req.ref_req));

    // R8: an idle driver implies no request on either line.
    a_r8_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_en_o |-> (!pump_up_o && !pump_dn_o));

    // R1: the cycle after reset shows no pump activity.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!pump_up_o && !pump_dn_o && !pump_en_o));

endmodule

// File: tb/tb_phase_freq_detector.sv
module tb_phase_freq_detector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic vco_in = 1'b0;
    logic cfg_invert_i = 1'b0;
    logic cfg_full_i = 1'b0;
    logic pump_up_o, pump_dn_o, pump_en_o, pump_full_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] v;   // {up, dn, en, full}
        string      tag;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    phase_freq_detector dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_in       (ref_in),
        .vco_in       (vco_in),
        .cfg_invert_i (cfg_invert_i),
        .cfg_full_i   (cfg_full_i),
        .pump_up_o    (pump_up_o),
        .pump_dn_o    (pump_dn_o),
        .pump_en_o    (pump_en_o),
        .pump_full_o  (pump_full_o)
    );

    // Driver side: queue one expected output set; enable follows R8.
    task automatic expect_at(int c, bit u, bit d, bit f, string tag);
        item_t it;
        it.at  = c;
        it.v   = {u, d, u | d, f};
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Step to just after the rising edge numbered c.
    task automatic go(int c);
        while (cyc < c) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: compare due items at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            logic [3:0] act;
            it  = sb.pop_front();
            act = {pump_up_o, pump_dn_o, pump_en_o, pump_full_o};
            n_chk++;
            if (it.at != cyc) begin
                n_fail++;
                $display("FAIL %s cycle %0d missed: actual %b expected %b", it.tag, it.at, act, it.v);
            end else if (act !== it.v) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual %b expected %b (up dn en full)", it.tag, cyc, act, it.v);
            end
        end
    end

    initial begin
        int c;
        repeat (4) @(posedge clk);
        #1;
        expect_at(cyc, 0, 0, 0, "R1 in reset");
        go(cyc + 1);
        rst_n = 1'b1;
        expect_at(cyc + 1, 0, 0, 0, "R1 after reset");
        go(cyc + 3);

        // R2 ref first, R10 falling ref ignored, R4 joint clear.
        c = cyc + 2;
        expect_at(c + 2, 0, 0, 0, "R2 before latency");
        expect_at(c + 3, 1, 0, 0, "R2 up raised");
        expect_at(c + 7, 1, 0, 0, "R10 ref fall ignored");
        expect_at(c + 8, 1, 1, 0, "R4 overlap 1");
        expect_at(c + 9, 1, 1, 0, "R4 overlap 2");
        expect_at(c + 10, 0, 0, 0, "R4 joint clear");
        expect_at(c + 13, 0, 0, 0, "R10 vco fall ignored");
        go(c);      ref_in = 1'b1;
        go(c + 4);  ref_in = 1'b0;
        go(c + 5);  vco_in = 1'b1;
        go(c + 9);  vco_in = 1'b0;
        go(c + 15);

        // R5 coincident edges.
        c = cyc + 2;
        expect_at(c + 3, 1, 1, 0, "R5 joint rise");
        expect_at(c + 4, 1, 1, 0, "R5 joint hold");
        expect_at(c + 5, 0, 0, 0, "R5 joint fall");
        go(c);      ref_in = 1'b1; vco_in = 1'b1;
        go(c + 6);  ref_in = 1'b0; vco_in = 1'b0;
        go(c + 10);

        // R3 VCO leads.
        c = cyc + 2;
        expect_at(c + 2, 0, 0, 0, "R3 before latency");
        expect_at(c + 3, 0, 1, 0, "R3 dn raised");
        expect_at(c + 4, 0, 1, 0, "R3 dn held");
        expect_at(c + 5, 1, 1, 0, "R4 overlap 1");
        expect_at(c + 6, 1, 1, 0, "R4 overlap 2");
        expect_at(c + 7, 0, 0, 0, "R4 joint clear");
        go(c);      vco_in = 1'b1;
        go(c + 2);  ref_in = 1'b1;
        go(c + 8);  ref_in = 1'b0; vco_in = 1'b0;
        go(c + 12);

        // R7 polarity swap.
        cfg_invert_i = 1'b1;
        c = cyc + 2;
        expect_at(c + 3, 0, 1, 0, "R7 ref drives dn");
        expect_at(c + 7, 1, 1, 0, "R7 overlap");
        expect_at(c + 8, 1, 1, 0, "R7 overlap 2");
        expect_at(c + 9, 0, 0, 0, "R7 clear");
        go(c);      ref_in = 1'b1;
        go(c + 2);  ref_in = 1'b0;
        go(c + 4);  vco_in = 1'b1;
        go(c + 10); vco_in = 1'b0;
        go(c + 11); cfg_invert_i = 1'b0;
        go(c + 14);

        // R6 reference faster: up held across repeated ref edges.
        c = cyc + 2;
        for (int k = 3; k <= 32; k++) expect_at(c + k, 1, 0, 0, "R6 up held");
        expect_at(c + 33, 1, 1, 0, "R6 overlap");
        expect_at(c + 34, 1, 1, 0, "R6 overlap 2");
        expect_at(c + 35, 0, 0, 0, "R6 clear");
        for (int k = 0; k < 5; k++) begin
            go(c + 6 * k);     ref_in = 1'b1;
            go(c + 6 * k + 3); ref_in = 1'b0;
        end
        go(c + 30); vco_in = 1'b1;
        go(c + 36); vco_in = 1'b0;
        go(c + 40);

        // R11 edge landing in the clear cycle.
        c = cyc + 2;
        expect_at(c + 3, 1, 1, 0, "R11 both set");
        expect_at(c + 4, 1, 1, 0, "R11 overlap");
        expect_at(c + 5, 1, 0, 0, "R11 set beats clear");
        expect_at(c + 10, 1, 1, 0, "R11 later overlap");
        expect_at(c + 11, 1, 1, 0, "R11 later overlap 2");
        expect_at(c + 12, 0, 0, 0, "R11 later clear");
        go(c);      ref_in = 1'b1; vco_in = 1'b1;
        go(c + 1);  ref_in = 1'b0;
        go(c + 2);  ref_in = 1'b1;
        go(c + 6);  ref_in = 1'b0; vco_in = 1'b0;
        go(c + 7);  vco_in = 1'b1;
        go(c + 13); vco_in = 1'b0;
        go(c + 16);

        // R9 current select passes through.
        c = cyc + 1;
        expect_at(c, 0, 0, 1, "R9 full");
        expect_at(c + 1, 0, 0, 0, "R9 half");
        go(c);      cfg_full_i = 1'b1;
        go(c + 1);  cfg_full_i = 1'b0;
        go(c + 3);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule